// File: doc/BRIEF.md
# SPI Master Byte Engine

This block is the transfer engine of a serial peripheral interface master. A single write strobe carrying a byte starts a transfer. The engine pulls the active-low slave select low, runs eight serial clock cycles while shifting the byte out on MOSI, and samples MISO on the opposite clock edge of each cycle. When the transfer ends it raises slave select again, copies the assembled byte into a receive buffer that the read port shows, and raises a done flag together with a one-cycle done pulse.

Clock polarity, clock phase and bit order are plain configuration inputs. They cover all four phase/polarity modes and either bit order, and the engine takes a copy of them when a transfer starts. A half-period input sets how many system clocks each SCK level lasts, so the serial clock is the system clock divided by an even number of at least two. The write port is a plain strobe with no back-pressure. A strobe that arrives while a transfer is running does not wait and does not queue. It is dropped, and a sticky collision flag records it. The read data is a separate buffered copy and never shows the live shift register.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, ss_n is 1 and xfer_done, done_pulse and wr_collision are 0.
- R2: While no transfer runs (ss_n high), sck equals cfg_cpol and follows it combinationally.
- R3: A wr_en strobe while idle starts a transfer of wr_data. ss_n is low in the following cycle and xfer_done reads 0.
- R4: Each transfer has exactly 16 SCK edges. MISO is sampled on edges 1,3,..,15 when cfg_cpha=0 and on edges 2,4,..,16 when cfg_cpha=1. MOSI changes only on the other edges. A sampling edge is rising when cfg_cpol equals cfg_cpha and falling otherwise, which gives mode number cpol*2+cpha.
- R5: With cfg_cpha=0, the first data bit is on MOSI while ss_n is low and before the first SCK edge.
- R6: cfg_lsb_first=0 sends bit 7 first. cfg_lsb_first=1 sends bit 0 first. Received bits are placed in the same order, so the first sampled bit lands in bit 7 or bit 0 respectively.
- R7: rd_data shows the receive buffer. It changes only when a transfer ends, and a new write does not alter it.
- R8: Each SCK level lasts cfg_half system clocks, and a value of 0 acts as 1. ss_n falls one half period before the first edge and rises one half period after the last edge.
- R9: At the end of a transfer, ss_n rises, rd_data takes the received byte, xfer_done becomes 1 and done_pulse is high for exactly one cycle, all on the same clock edge. xfer_done stays 1 until the next accepted write.
- R10: A wr_en strobe while a transfer runs is ignored: the byte in flight is unchanged and no extra transfer follows. It sets wr_collision, which clears on the next accepted write.
- R11: Configuration inputs are captured when a transfer starts. Changing them during a transfer does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Clock polarity (SCK idle level) |
| cfg_cpha | input | 1 | Clock phase: 0 samples on leading edge, 1 on trailing |
| cfg_lsb_first | input | 1 | Bit order: 1 sends and assembles LSB first |
| cfg_half | input | DIVW (8) | System clocks per SCK half period, 0 treated as 1 |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | DW (8) | Byte to transmit |
| rd_data | output | DW (8) | Receive buffer |
| xfer_done | output | 1 | Sticky end-of-transfer flag |
| done_pulse | output | 1 | One-cycle end-of-transfer pulse |
| wr_collision | output | 1 | Sticky flag for a write that was dropped while busy |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
The hardest case to reach from the ports is a write strobe that lands in the middle of a running transfer while the configuration inputs also change. Only that case can show whether the dropped byte or the new settings leak into the bits already on the wire. The bench starts a transfer with a known byte and format. It waits a random number of cycles, then strobes a different byte and flips every configuration input. A bench-side slave model that keeps its own copy of the original format then checks the captured MOSI byte, the returned MISO byte, the edge directions and the collision flag. Random transfers over all four modes, both bit orders and several divider values, including zero, cover the rest.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb;
  } spi_fmt_t;
endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] half,
  output logic            tick
);
  logic [DIVW-1:0] cnt;
  logic [DIVW-1:0] lim;

  assign lim  = (half == '0) ? '0 : half - 1'b1;
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (cnt == lim) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_sequencer.sv
module spi_sequencer
  import spi_eng_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     tick,
  input  spi_fmt_t fmt,
  input  logic     cpol_live,
  output logic     busy,
  output logic     sck,
  output logic     ss_n,
  output logic     sample_en,
  output logic     shift_en,
  output logic     finish
);
  localparam int EDGES = 2 * DW;
  localparam int CW    = $clog2(EDGES + 2);

  logic [CW-1:0] ecnt;
  logic [CW-1:0] nxt;
  logic          sck_q;
  logic          edge_now;

  assign nxt       = ecnt + 1'b1;
  assign edge_now  = busy && tick && (nxt <= CW'(EDGES));
  assign sample_en = edge_now && (nxt[0] ^ fmt.cpha);
  assign shift_en  = edge_now && !(nxt[0] ^ fmt.cpha) && !(fmt.cpha && nxt == CW'(1));
  assign finish    = busy && tick && (nxt == CW'(EDGES + 1));
  assign sck       = busy ? sck_q : cpol_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ss_n  <= 1'b1;
      ecnt  <= '0;
      sck_q <= 1'b0;
    end else if (start) begin
      busy  <= 1'b1;
      ss_n  <= 1'b0;
      ecnt  <= '0;
      sck_q <= cpol_live;
    end else if (busy && tick) begin
      ecnt <= nxt;
      if (edge_now) sck_q <= ~sck_q;
      if (finish) begin
        busy <= 1'b0;
        ss_n <= 1'b1;
      end
    end
  end

  // R3
  start_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ss_n);
  // R8
  sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tick |=> $stable(sck_q));
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          lsb,
  input  logic          shift_en,
  input  logic          sample_en,
  input  logic          finish,
  input  logic          miso,
  output logic          mosi,
  output logic [DW-1:0] rx_buf
);
  logic [DW-1:0] tx;
  logic [DW-1:0] rx;

  assign mosi = lsb ? tx[0] : tx[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx <= '0;
      rx <= '0;
    end else if (load) begin
      tx <= din;
      rx <= '0;
    end else begin
      if (shift_en) tx <= lsb ? {1'b0, tx[DW-1:1]} : {tx[DW-2:0], 1'b0};
      if (sample_en) rx <= lsb ? {miso, rx[DW-1:1]} : {rx[DW-2:0], miso};
    end
  end

  always_ff @(posedge clk) begin
    if (finish) rx_buf <= rx;
  end

  // R4
  mosi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> $stable(mosi));
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_eng_pkg::*;
#(
  parameter int DW   = 8,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_cpol,
  input  logic            cfg_cpha,
  input  logic            cfg_lsb_first,
  input  logic [DIVW-1:0] cfg_half,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  output logic            xfer_done,
  output logic            done_pulse,
  output logic            wr_collision,
  output logic            sck,
  output logic            mosi,
  input  logic            miso,
  output logic            ss_n
);
  spi_fmt_t        fmt_q;
  logic [DIVW-1:0] half_q;
  logic            busy, start, tick, sample_en, shift_en, finish;

  assign start = wr_en && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q        <= '0;
      half_q       <= '0;
      xfer_done    <= 1'b0;
      done_pulse   <= 1'b0;
      wr_collision <= 1'b0;
    end else begin
      done_pulse <= finish;
      if (start) begin
        fmt_q        <= '{cpol: cfg_cpol, cpha: cfg_cpha, lsb: cfg_lsb_first};
        half_q       <= cfg_half;
        xfer_done    <= 1'b0;
        wr_collision <= 1'b0;
      end else begin
        if (finish) xfer_done <= 1'b1;
        if (wr_en)  wr_collision <= 1'b1;
      end
    end
  end

  spi_tick_gen #(.DIVW(DIVW)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .half(half_q), .tick(tick)
  );

  spi_sequencer #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .fmt(fmt_q),
    .cpol_live(cfg_cpol), .busy(busy), .sck(sck), .ss_n(ss_n),
    .sample_en(sample_en), .shift_en(shift_en), .finish(finish)
  );

  spi_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(start), .din(wr_data), .lsb(fmt_q.lsb),
    .shift_en(shift_en), .sample_en(sample_en), .finish(finish),
    .miso(miso), .mosi(mosi), .rx_buf(rd_data)
  );

  // R10
  wr_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && busy |=> wr_collision);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> ss_n && xfer_done);
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);
endmodule

// File: tb/spi_byte_master_bench.sv
`timescale 1ns/100ps
module spi_byte_master_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
  logic [7:0] cfg_half = 8'd1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       xfer_done, done_pulse, wr_collision, sck, mosi, ss_n;
  logic       miso = 1'b0;

  int checks = 0, fails = 0;
  int cycles = 0;
  bit finished = 0;

  // bench-side slave model state
  logic       b_cpol, b_cpha, b_lsb;
  logic [7:0] s_tx, cap;
  int         ecnt_b, dir_err;
  bit         first_ok;
  realtime    t_ss, t_first, t_last, t_end;

  always #2.5 clk = ~clk;

  spi_byte_master u_spi_byte_master (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .cfg_half(cfg_half), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .xfer_done(xfer_done),
    .done_pulse(done_pulse), .wr_collision(wr_collision), .sck(sck),
    .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  function automatic int pos(int i);
    return b_lsb ? i : 7 - i;
  endfunction

  always @(negedge ss_n) begin
    ecnt_b = 0; cap = 8'h00; dir_err = 0; t_ss = $realtime;
    if (!b_cpha) miso = s_tx[pos(0)];
  end
  always @(posedge ss_n) t_end = $realtime;

  always @(sck) begin
    if (!ss_n) begin
      ecnt_b++;
      if (ecnt_b == 1) begin
        t_first = $realtime;
        first_ok = (mosi === wr_data[b_lsb ? 0 : 7]);
      end
      t_last = $realtime;
      if (b_cpha ? (ecnt_b % 2 == 0) : (ecnt_b % 2 == 1)) begin
        int i;
        i = b_cpha ? ecnt_b / 2 - 1 : (ecnt_b - 1) / 2;
        if (i < 8) cap[pos(i)] = mosi;
        if (sck !== (b_cpol == b_cpha)) dir_err++;
      end else begin
        int i;
        i = b_cpha ? (ecnt_b - 1) / 2 : ecnt_b / 2;
        if (i < 8) miso = s_tx[pos(i)];
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected under 150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic [7:0] d);
    wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (done_pulse) break;
    end
  endtask

  // full transfer with independent expectations
  task automatic xfer(input logic cp, input logic ch, input logic lf,
                      input logic [7:0] hv, input logic [7:0] d,
                      input logic [7:0] sd, input bit collide);
    logic [7:0] old_rx;
    int heff;
    heff = (hv == 0) ? 1 : hv;
    cfg_cpol = cp; cfg_cpha = ch; cfg_lsb_first = lf; cfg_half = hv;
    b_cpol = cp; b_cpha = ch; b_lsb = lf; s_tx = sd;
    @(negedge clk);
    chk(sck == cp, "R2 idle sck", sck, cp);
    old_rx = rd_data;
    strobe(d);
    chk(ss_n == 1'b0, "R3 ss_n low after write", ss_n, 0);
    chk(xfer_done == 1'b0, "R3 done cleared by write", xfer_done, 0);
    chk(rd_data === old_rx, "R7 rd_data kept on write", rd_data, old_rx);
    if (collide) begin
      repeat ($urandom_range(1, 8 * heff)) @(negedge clk);
      cfg_cpol = ~cp; cfg_cpha = ~ch; cfg_lsb_first = ~lf;
      cfg_half = (hv == 0) ? 8'd3 : hv + 8'd1;
      strobe(~d);
      chk(wr_collision == 1'b1, "R10 collision flag set", wr_collision, 1);
    end
    wait_done();
    chk(done_pulse && ss_n && xfer_done, "R9 end state", {done_pulse, ss_n, xfer_done}, 3'b111);
    chk(cap == d, collide ? "R11/R10 mosi byte" : "R6 mosi byte", cap, d);
    chk(rd_data == sd, "R6/R7 received byte", rd_data, sd);
    chk(ecnt_b == 16, "R4 edge count", ecnt_b, 16);
    chk(dir_err == 0, "R4 sample edge direction", dir_err, 0);
    if (!ch) chk(first_ok, "R5 first bit before first edge", first_ok, 1);
    chk(int'((t_first - t_ss) / 5.0 + 0.01) == heff, "R8 lead time", int'((t_first - t_ss) / 5.0), heff);
    chk(int'((t_end - t_last) / 5.0 + 0.01) == heff, "R8 tail time", int'((t_end - t_last) / 5.0), heff);
    @(negedge clk);
    chk(done_pulse == 1'b0 && xfer_done, "R9 pulse one cycle, flag sticky", done_pulse, 0);
    if (collide) chk(ss_n == 1'b1, "R10 no extra transfer", ss_n, 1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    b_cpol = 0; b_cpha = 0; b_lsb = 0; s_tx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ss_n == 1'b1, "R1 ss_n reset", ss_n, 1);
    chk(!xfer_done && !done_pulse && !wr_collision, "R1 flags reset",
        {xfer_done, done_pulse, wr_collision}, 0);
    cfg_cpol = 1'b1; #1;
    chk(sck == 1'b1, "R2 sck follows cpol high", sck, 1);
    cfg_cpol = 1'b0; #1;
    chk(sck == 1'b0, "R2 sck follows cpol low", sck, 0);

    // directed: every mode in both orders
    for (int m = 0; m < 8; m++)
      xfer(m[1], m[0], m[2], 8'd2, 8'hA6 ^ 8'(m), 8'h3C + 8'(m), 0);
    // divider corner values
    xfer(0, 0, 0, 8'd0, 8'h81, 8'h7E, 0);
    xfer(1, 1, 1, 8'd1, 8'h01, 8'h80, 0);
    xfer(0, 1, 0, 8'd5, 8'hFF, 8'h00, 0);
    // collision with config change mid-transfer
    xfer(1, 0, 1, 8'd3, 8'hC5, 8'h5A, 1);
    xfer(0, 1, 0, 8'd0, 8'h3B, 8'hE4, 1);
    // next accepted write clears collision flag
    b_cpol = 0; b_cpha = 0; b_lsb = 0;
    cfg_cpol = 0; cfg_cpha = 0; cfg_lsb_first = 0; cfg_half = 8'd1;
    @(negedge clk);
    strobe(8'h11);
    chk(wr_collision == 1'b0, "R10 collision cleared by write", wr_collision, 0);
    wait_done();
    @(negedge clk);
    // random transfers
    for (int n = 0; n < 40; n++)
      xfer(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom_range(0, 4)),
           8'($urandom), 8'($urandom), ($urandom_range(0, 5) == 0));

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule